// File: doc/BRIEF.md
# Prioritized Exception Vector Generator

This block sits beside a CPU core. It gathers every request that can redirect program flow: three classes of reset, an unimplemented-opcode trap, a software-interrupt or debug vector request, an X-class request, an IRQ request and up to 56 peripheral interrupt lines. It raises a pending flag whenever any unmasked source is active. When the CPU strobes a vector request, the block picks the winning source and returns its 16-bit vector address one cycle later.

Reset vectors are fixed absolute addresses. Every other vector is built from a relocatable base byte, which forms the upper half of the address, and a fixed low-byte offset. Selection happens again in the strobe cycle itself. If the request that raised the pending flag has gone away by then, nothing qualifies and the CPU receives the spurious vector.

Top module: `excvec_gen`

## Requirements
- R1: After reset, `vec_out` is 0x0000, `vec_valid` is 0 and the vector base byte is 0xFF.
- R2: Any active reset request wins over every other source, whatever `mask_i` and `mask_x` hold. Power-on class gives 0xFFFE, clock-monitor gives 0xFFFC and watchdog gives 0xFFFA, with priority in that order.
- R3: Below the resets, the priority order is trap, then swi, then X-class, then IRQ. Their vectors are {base, 0xF8}, {base, 0xF6}, {base, 0xF4} and {base, 0xF2}.
- R4: Peripheral line k (bit k of `periph_req`) gives vector {base, 0xF0 − 2k}. A lower k has higher priority. All peripheral lines rank below IRQ.
- R5: When `mask_x` is 1, `xreq` is ignored. When `mask_i` is 1, `irq_req` and all of `periph_req` are ignored. Neither mask bit has any effect on the trap or on swi.
- R6: If no unmasked source is active in the strobe cycle, the vector is the spurious vector {base, 0x80}. This includes the case where a request was withdrawn after it raised `int_pending`.
- R7: `int_pending` is combinational. It is 1 exactly when at least one source is active after masking, with resets, trap and swi counted as always unmasked.
- R8: `vec_valid` is 1 for exactly the cycle after each cycle in which `vec_req` is 1. `vec_out` changes only in that cycle and holds its value at all other times.
- R9: When `base_load` is 1, `base_in` is captured at the clock edge. A strobe sampled at that same edge still uses the old base. Strobes sampled at later edges use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_por_req | input | 1 | Power-on / pin / illegal-address / low-voltage reset request |
| rst_clkmon_req | input | 1 | Clock-monitor reset request |
| rst_cop_req | input | 1 | Watchdog reset request |
| trap_req | input | 1 | Unimplemented-opcode trap |
| swi_req | input | 1 | Software interrupt or debug vector request |
| xreq | input | 1 | X-class request, maskable by `mask_x` |
| irq_req | input | 1 | IRQ request, maskable by `mask_i` |
| periph_req | input | NUM_PERIPH | Peripheral interrupt lines, bit 0 highest priority |
| base_load | input | 1 | Load strobe for the vector base |
| base_in | input | 8 | New vector base byte |
| mask_i | input | 1 | CPU I mask bit |
| mask_x | input | 1 | CPU X mask bit |
| vec_req | input | 1 | CPU vector-request strobe |
| int_pending | output | 1 | Some unmasked source is active |
| vec_out | output | 16 | Registered vector address |
| vec_valid | output | 1 | `vec_out` was loaded in the previous cycle's strobe |

## Verification
A fault in the priority chain or in the masking shows as a wrong `vec_out` exactly one cycle after the strobe. A fault in the masking also shows at once on the combinational `int_pending`. A corrupted base register stays hidden until the next non-reset vector, and then appears as a wrong upper byte. A fault in the output register shows as `vec_out` drifting between strobes, or as `vec_valid` arriving a cycle late or lasting too long. The reference model compares all three outputs on every clock, so each of these faults appears at the first cycle where it makes a difference.

// File: rtl/excvec_pkg.sv
package excvec_pkg;

   localparam int VEC_W  = 16;
   localparam int BASE_W = 8;
   localparam int OFF_W  = 8;

   localparam logic [VEC_W-1:0] VEC_RST_POR    = 16'hFFFE;
   localparam logic [VEC_W-1:0] VEC_RST_CLKMON = 16'hFFFC;
   localparam logic [VEC_W-1:0] VEC_RST_COP    = 16'hFFFA;

   localparam logic [OFF_W-1:0] OFF_TRAP    = 8'hF8;
   localparam logic [OFF_W-1:0] OFF_SWI     = 8'hF6;
   localparam logic [OFF_W-1:0] OFF_XREQ    = 8'hF4;
   localparam logic [OFF_W-1:0] OFF_IRQ     = 8'hF2;
   localparam logic [OFF_W-1:0] OFF_PERIPH0 = 8'hF0;
   localparam logic [OFF_W-1:0] OFF_SPUR    = 8'h80;

   localparam int MAX_PERIPH = (OFF_PERIPH0 - OFF_SPUR) / 2;

   typedef enum logic [3:0] {
      SRC_NONE,
      SRC_POR,
      SRC_CLKMON,
      SRC_COP,
      SRC_TRAP,
      SRC_SWI,
      SRC_XREQ,
      SRC_IRQ,
      SRC_PERIPH
   } src_e;

   function automatic logic [VEC_W-1:0] join_vec(input logic [BASE_W-1:0] base,
                                                 input logic [OFF_W-1:0]  off);
      return {base, off};
   endfunction

endpackage

// File: rtl/excvec_base_reg.sv
module excvec_base_reg #(
   parameter int          WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (load) begin
         q <= din;
      end
   end

endmodule

// File: rtl/excvec_periph_prio.sv
module excvec_periph_prio
   import excvec_pkg::*;
#(
   parameter int NUM_PERIPH = 56,
   localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
   input  logic [NUM_PERIPH-1:0] req,
   output logic                  any,
   output logic [OFF_W-1:0]      off
);

   logic [NUM_PERIPH:0]   seen;
   logic [NUM_PERIPH-1:0] win;
   logic [IDX_W-1:0]      idx;

   assign seen[0] = 1'b0;

   for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_chain
      assign win[g]    = req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req[g];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_PERIPH; i++) begin
         if (win[i]) begin
            idx = idx | IDX_W'(i);
         end
      end
   end

   assign any = seen[NUM_PERIPH];
   assign off = OFF_PERIPH0 - (OFF_W'(idx) << 1);

endmodule

// File: rtl/excvec_select.sv
module excvec_select
   import excvec_pkg::*;
(
   input  logic               por,
   input  logic               clkmon,
   input  logic               cop,
   input  logic               trap,
   input  logic               swi,
   input  logic               x_ok,
   input  logic               irq_ok,
   input  logic               periph_ok,
   input  logic [OFF_W-1:0]   periph_off,
   input  logic [BASE_W-1:0]  base,
   output src_e               src,
   output logic [VEC_W-1:0]   vec
);

   always_comb begin
      if (por)            src = SRC_POR;
      else if (clkmon)    src = SRC_CLKMON;
      else if (cop)       src = SRC_COP;
      else if (trap)      src = SRC_TRAP;
      else if (swi)       src = SRC_SWI;
      else if (x_ok)      src = SRC_XREQ;
      else if (irq_ok)    src = SRC_IRQ;
      else if (periph_ok) src = SRC_PERIPH;
      else                src = SRC_NONE;
   end

   always_comb begin
      unique case (src)
         SRC_POR:    vec = VEC_RST_POR;
         SRC_CLKMON: vec = VEC_RST_CLKMON;
         SRC_COP:    vec = VEC_RST_COP;
         SRC_TRAP:   vec = join_vec(base, OFF_TRAP);
         SRC_SWI:    vec = join_vec(base, OFF_SWI);
         SRC_XREQ:   vec = join_vec(base, OFF_XREQ);
         SRC_IRQ:    vec = join_vec(base, OFF_IRQ);
         SRC_PERIPH: vec = join_vec(base, periph_off);
         default:    vec = join_vec(base, OFF_SPUR);
      endcase
   end

endmodule

// File: rtl/excvec_gen.sv
module excvec_gen
   import excvec_pkg::*;
#(
   parameter int               NUM_PERIPH = 56,
   parameter logic [BASE_W-1:0] BASE_RST  = 8'hFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rst_por_req,
   input  logic                  rst_clkmon_req,
   input  logic                  rst_cop_req,
   input  logic                  trap_req,
   input  logic                  swi_req,
   input  logic                  xreq,
   input  logic                  irq_req,
   input  logic [NUM_PERIPH-1:0] periph_req,
   input  logic                  base_load,
   input  logic [BASE_W-1:0]     base_in,
   input  logic                  mask_i,
   input  logic                  mask_x,
   input  logic                  vec_req,
   output logic                  int_pending,
   output logic [VEC_W-1:0]      vec_out,
   output logic                  vec_valid
);

   if (NUM_PERIPH < 1 || NUM_PERIPH > MAX_PERIPH) begin : g_bad_count
      $error("NUM_PERIPH must lie between 1 and the number of peripheral slots");
   end

   logic [BASE_W-1:0] base_q;
   logic              x_ok;
   logic              irq_ok;
   logic              periph_any;
   logic              periph_ok;
   logic [OFF_W-1:0]  periph_off;
   src_e              src;
   logic [VEC_W-1:0]  vec_next;

   excvec_base_reg #(
      .WIDTH   (BASE_W),
      .RST_VAL (BASE_RST)
   ) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (base_load),
      .din   (base_in),
      .q     (base_q)
   );

   excvec_periph_prio #(
      .NUM_PERIPH (NUM_PERIPH)
   ) u_prio (
      .req (periph_req),
      .any (periph_any),
      .off (periph_off)
   );

   assign x_ok      = xreq & ~mask_x;
   assign irq_ok    = irq_req & ~mask_i;
   assign periph_ok = periph_any & ~mask_i;

   excvec_select u_sel (
      .por        (rst_por_req),
      .clkmon     (rst_clkmon_req),
      .cop        (rst_cop_req),
      .trap       (trap_req),
      .swi        (swi_req),
      .x_ok       (x_ok),
      .irq_ok     (irq_ok),
      .periph_ok  (periph_ok),
      .periph_off (periph_off),
      .base       (base_q),
      .src        (src),
      .vec        (vec_next)
   );

   assign int_pending = (src != SRC_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= vec_req;
         if (vec_req) begin
            vec_out <= vec_next;
         end
      end
   end

endmodule

// File: rtl/excvec_chk.sv
module excvec_chk #(
   parameter int NUM_PERIPH = 56
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rst_por_req,
   input logic                  trap_req,
   input logic                  swi_req,
   input logic [NUM_PERIPH-1:0] periph_req,
   input logic                  mask_i,
   input logic                  vec_req,
   input logic                  int_pending,
   input logic [15:0]           vec_out,
   input logic                  vec_valid
);

   assert_valid_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |=> vec_valid);

   assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_req |=> !vec_valid);

   assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_req |=> $stable(vec_out));

   assert_por_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && rst_por_req) |=> (vec_out == 16'hFFFE));

   assert_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && !int_pending) |=> (vec_out[7:0] == 8'h80));

   assert_periph_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|periph_req) && !mask_i) |-> int_pending);

   assert_trap_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req || swi_req) |-> int_pending);

endmodule

bind excvec_gen excvec_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rst_por_req (rst_por_req),
   .trap_req    (trap_req),
   .swi_req     (swi_req),
   .periph_req  (periph_req),
   .mask_i      (mask_i),
   .vec_req     (vec_req),
   .int_pending (int_pending),
   .vec_out     (vec_out),
   .vec_valid   (vec_valid)
);

// File: tb/tb_excvec_gen.sv
`timescale 1ns/1ps
module tb_excvec_gen;

   localparam int NP = 56;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rst_por_req = 0, rst_clkmon_req = 0, rst_cop_req = 0;
   logic          trap_req = 0, swi_req = 0, xreq = 0, irq_req = 0;
   logic [NP-1:0] periph_req = '0;
   logic          base_load = 0;
   logic [7:0]    base_in = '0;
   logic          mask_i = 0, mask_x = 0, vec_req = 0;
   logic          int_pending;
   logic [15:0]   vec_out;
   logic          vec_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   excvec_gen #(.NUM_PERIPH(NP)) dut (
      .clk(clk), .rst_n(rst_n),
      .rst_por_req(rst_por_req), .rst_clkmon_req(rst_clkmon_req), .rst_cop_req(rst_cop_req),
      .trap_req(trap_req), .swi_req(swi_req), .xreq(xreq), .irq_req(irq_req),
      .periph_req(periph_req), .base_load(base_load), .base_in(base_in),
      .mask_i(mask_i), .mask_x(mask_x), .vec_req(vec_req),
      .int_pending(int_pending), .vec_out(vec_out), .vec_valid(vec_valid)
   );

   // Behavioural reference model
   logic [7:0]  m_base;
   logic [15:0] m_vec;
   logic        m_valid;

   function automatic logic [16:0] ref_pick(input logic [7:0] b);
      if (rst_por_req)    return {1'b1, 16'hFFFE};
      if (rst_clkmon_req) return {1'b1, 16'hFFFC};
      if (rst_cop_req)    return {1'b1, 16'hFFFA};
      if (trap_req)       return {1'b1, b, 8'hF8};
      if (swi_req)        return {1'b1, b, 8'hF6};
      if (xreq && !mask_x)   return {1'b1, b, 8'hF4};
      if (irq_req && !mask_i) return {1'b1, b, 8'hF2};
      if (!mask_i) begin
         for (int k = 0; k < NP; k++) begin
            if (periph_req[k]) begin
               int off = 240 - 2 * k;
               return {1'b1, b, off[7:0]};
            end
         end
      end
      return {1'b0, b, 8'h80};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_base  <= 8'hFF;
         m_vec   <= 16'h0000;
         m_valid <= 1'b0;
      end else begin
         logic [16:0] p;
         p = ref_pick(m_base);
         m_valid <= vec_req;
         if (vec_req) m_vec <= p[15:0];
         if (base_load) m_base <= base_in;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [16:0] p;
         p = ref_pick(m_base);
         check("R7 pending", {31'd0, int_pending}, {31'd0, p[16]});
         check("R8 vec_out", {16'd0, vec_out}, {16'd0, m_vec});
         check("R8 vec_valid", {31'd0, vec_valid}, {31'd0, m_valid});
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic clear_all();
      rst_por_req = 0; rst_clkmon_req = 0; rst_cop_req = 0;
      trap_req = 0; swi_req = 0; xreq = 0; irq_req = 0;
      periph_req = '0; mask_i = 0; mask_x = 0; base_load = 0;
   endtask

   // Inputs are already set; strobe now, check vector after the sampling edge
   task automatic strobe(input string tag, input logic [15:0] exp);
      vec_req = 1;
      @(posedge clk); #1;
      vec_req = 0;
      @(negedge clk);
      check(tag, {16'd0, vec_out}, {16'd0, exp});
      check({tag, " valid"}, {31'd0, vec_valid}, 32'd1);
      @(posedge clk); #1;
      clear_all();
   endtask

   initial begin
      #200000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      step(); step();
      @(negedge clk);
      check("R1 reset vec_out", {16'd0, vec_out}, 32'd0);
      check("R1 reset vec_valid", {31'd0, vec_valid}, 32'd0);
      @(posedge clk); #1;
      rst_n = 1;
      step();
      strobe("R1 default base spurious", 16'hFF80);

      // Single sources
      rst_por_req = 1;    strobe("R2 por", 16'hFFFE);
      rst_clkmon_req = 1; strobe("R2 clkmon", 16'hFFFC);
      rst_cop_req = 1;    strobe("R2 cop", 16'hFFFA);
      trap_req = 1;       strobe("R3 trap", 16'hFFF8);
      swi_req = 1;        strobe("R3 swi", 16'hFFF6);
      xreq = 1;           strobe("R3 xreq", 16'hFFF4);
      irq_req = 1;        strobe("R3 irq", 16'hFFF2);
      periph_req[0] = 1;  strobe("R4 periph0", 16'hFFF0);
      periph_req[20] = 1; strobe("R4 periph20", 16'hFFC8);
      periph_req[55] = 1; strobe("R4 periph55", 16'hFF82);

      // Pairs
      rst_clkmon_req = 1; rst_cop_req = 1; strobe("R2 clkmon over cop", 16'hFFFC);
      rst_por_req = 1; rst_clkmon_req = 1; strobe("R2 por over clkmon", 16'hFFFE);
      rst_cop_req = 1; trap_req = 1; strobe("R2 cop over trap", 16'hFFFA);
      trap_req = 1; swi_req = 1; strobe("R3 trap over swi", 16'hFFF8);
      swi_req = 1; xreq = 1; strobe("R3 swi over xreq", 16'hFFF6);
      xreq = 1; irq_req = 1; strobe("R3 xreq over irq", 16'hFFF4);
      irq_req = 1; periph_req[0] = 1; strobe("R4 irq over periph", 16'hFFF2);
      periph_req[3] = 1; periph_req[10] = 1; strobe("R4 low index wins", 16'hFFEA);

      // Masking
      mask_x = 1; xreq = 1; irq_req = 1; strobe("R5 x masked", 16'hFFF2);
      mask_i = 1; irq_req = 1; periph_req[5] = 1; xreq = 1; strobe("R5 i masked", 16'hFFF4);
      mask_i = 1; mask_x = 1; irq_req = 1; xreq = 1; periph_req = '1;
      @(negedge clk);
      check("R7 pending all masked", {31'd0, int_pending}, 32'd0);
      @(posedge clk); #1;
      strobe("R5 all masked spurious", 16'hFF80);
      mask_i = 1; mask_x = 1; trap_req = 1; strobe("R5 trap unmaskable", 16'hFFF8);
      mask_i = 1; mask_x = 1; swi_req = 1; strobe("R5 swi unmaskable", 16'hFFF6);
      mask_i = 1; mask_x = 1; rst_cop_req = 1; trap_req = 1; strobe("R2 reset ignores masks", 16'hFFFA);

      // Base relocation: strobe in load cycle uses old base
      base_in = 8'h40; base_load = 1; irq_req = 1;
      strobe("R9 old base at load edge", 16'hFFF2);
      irq_req = 1; strobe("R9 new base irq", 16'h40F2);
      strobe("R9 new base spurious", 16'h4080);
      rst_por_req = 1; strobe("R2 reset ignores base", 16'hFFFE);

      // Withdrawn request
      irq_req = 1;
      @(negedge clk);
      check("R7 pending irq", {31'd0, int_pending}, 32'd1);
      @(posedge clk); #1;
      irq_req = 0;
      strobe("R6 withdrawn spurious", 16'h4080);

      // Hold between strobes
      repeat (4) step();
      @(negedge clk);
      check("R8 hold vec_out", {16'd0, vec_out}, 32'h4080);
      check("R8 valid low", {31'd0, vec_valid}, 32'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule